// File: doc/BRIEF.md
# Programmable Millisecond Tick Generator

This block turns the module clock into a one-cycle tick that repeats once per millisecond. Software tells it how fast the clock runs by writing a 10-bit speed value and a unit bit through a small register-style write port. The unit bit says whether the speed is given in kHz or in MHz. From these two fields the block derives the number of clock cycles in one millisecond, counts cycles, and raises the tick whenever a full period has elapsed.

The configuration register can be read back at any time. A write that alters either field restarts the cycle count, so no tick is ever timed partly under the old setting and partly under the new one. A speed below the legal floor is raised to that floor inside the period calculation, so the block never runs a zero-length or degenerate period. The write port and the tick are plain control pins; there is no data stream and no back-pressure.

Top module: `ms_tick_gen`

## Requirements
- R1: The configuration word is 12 bits: bit 0 is the unit (0 = kHz, 1 = MHz), bits 11:2 are the speed, bit 1 is reserved. `cfg_rdata` returns the stored unit and speed with bit 1 always reading 0; a write sets both fields at the clock edge where `cfg_we` is high.
- R2: After reset `cfg_rdata` reads 0xC1 (MHz, speed 48), so the tick period is 48000 cycles.
- R3: In kHz mode with speed S (S >= 4) the tick period is exactly S cycles.
- R4: In MHz mode with speed S (S >= 1) the tick period is exactly S*1000 cycles.
- R5: `tick` is high for one cycle per period. The first tick after reset appears in the cycle after the P-th rising edge with reset released, where P is the period; later ticks follow every P cycles.
- R6: A speed below the floor is clamped in the period calculation: kHz speeds 0 to 3 give 4 cycles and MHz speed 0 gives 1000 cycles; `cfg_rdata` still shows the raw written value.
- R7: A write that changes the unit or the speed clears the count at that edge; the next tick comes exactly P cycles later, with P from the new setting, and no tick is issued in the cycle after the write.
- R8: A write whose unit and speed equal the stored ones (bit 1 may differ) does not disturb the count: ticks keep their previous spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock being measured |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 12 | Configuration word: speed at 11:2, unit at 0 |
| cfg_rdata | output | 12 | Stored configuration, bit 1 reads 0 |
| tick | output | 1 | One-cycle pulse once per millisecond |

## Verification
The bench targets the clamp floors in both units, where a design without clamping would compare against a limit of zero or underflow and either tick every cycle or never. It rewrites the same setting mid-period, which a design restarting on every write would answer with a late tick, and changes only the unit bit, which a design watching only the speed would fail to restart. It also runs the reset period and a MHz setting, where a wrong multiplier or an off-by-one terminal count shifts every tick by a cycle or by whole thousands of cycles.

// File: rtl/ms_tick_pkg.sv
package ms_tick_pkg;

  typedef enum logic {
    UNIT_KHZ = 1'b0,
    UNIT_MHZ = 1'b1
  } rate_unit_e;

  localparam int unsigned UNIT_BIT  = 0;
  localparam int unsigned SPEED_LSB = 2;

endpackage

// File: rtl/mst_cfg_reg.sv
module mst_cfg_reg
  import ms_tick_pkg::*;
#(
  parameter int unsigned SPEED_W   = 10,
  parameter int unsigned RST_SPEED = 48,
  parameter bit          RST_UNIT  = 1'b1,
  localparam int unsigned WORD_W   = SPEED_W + SPEED_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [SPEED_W-1:0] speed_o,
  output rate_unit_e         unit_o,
  output logic               restart_o
);

  logic [SPEED_W-1:0] speed_q;
  rate_unit_e         unit_q;
  logic [SPEED_W-1:0] new_speed;
  rate_unit_e         new_unit;

  assign new_speed = wdata_i[SPEED_LSB +: SPEED_W];
  assign new_unit  = rate_unit_e'(wdata_i[UNIT_BIT]);

  // A write restarts the count only when it alters a field.
  assign restart_o = we_i && ((new_speed != speed_q) || (new_unit != unit_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_q <= SPEED_W'(RST_SPEED);
      unit_q  <= rate_unit_e'(RST_UNIT);
    end else if (we_i) begin
      speed_q <= new_speed;
      unit_q  <= new_unit;
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[SPEED_LSB +: SPEED_W]  = speed_q;
    rdata_o[UNIT_BIT]              = unit_q;
  end

  assign speed_o = speed_q;
  assign unit_o  = unit_q;

  // R8: without a write the setting holds.
  p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(rdata_o));

endmodule

// File: rtl/mst_period_calc.sv
module mst_period_calc
  import ms_tick_pkg::*;
#(
  parameter int unsigned SPEED_W  = 10,
  parameter int unsigned MHZ_MULT = 1000,
  parameter int unsigned KHZ_MIN  = 4,
  parameter int unsigned MHZ_MIN  = 1,
  parameter int unsigned CNT_W    = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPEED_W-1:0] speed_i,
  input  rate_unit_e         unit_i,
  output logic [CNT_W-1:0]   period_o
);

  logic [SPEED_W-1:0] eff_speed;

  always_comb begin
    eff_speed = speed_i;
    if (unit_i == UNIT_MHZ) begin
      if (speed_i < SPEED_W'(MHZ_MIN)) eff_speed = SPEED_W'(MHZ_MIN);
    end else begin
      if (speed_i < SPEED_W'(KHZ_MIN)) eff_speed = SPEED_W'(KHZ_MIN);
    end
  end

  generate
    if (MHZ_MULT == 1) begin : g_unity
      assign period_o = CNT_W'(eff_speed);
    end else begin : g_scaled
      assign period_o = (unit_i == UNIT_MHZ) ? CNT_W'(eff_speed) * CNT_W'(MHZ_MULT)
                                             : CNT_W'(eff_speed);
    end
  endgenerate

  // R6: the period never drops below the floor of the selected unit.
  p_period_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_i == UNIT_MHZ) ? (period_o >= CNT_W'(MHZ_MIN * MHZ_MULT))
                         : (period_o >= CNT_W'(KHZ_MIN)));

endmodule

// File: rtl/mst_cycle_counter.sv
module mst_cycle_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle = (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (last_cycle) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R5: the tick lasts exactly one cycle.
  p_tick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R5: the count stays inside the current period.
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_i);

  // R7: a restart leaves a cleared count and no tick.
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0) && !tick_o);

endmodule

// File: rtl/ms_tick_gen.sv
module ms_tick_gen
  import ms_tick_pkg::*;
#(
  parameter int unsigned SPEED_W   = 10,
  parameter int unsigned MHZ_MULT  = 1000,
  parameter int unsigned KHZ_MIN   = 4,
  parameter int unsigned MHZ_MIN   = 1,
  parameter int unsigned RST_SPEED = 48,
  parameter bit          RST_UNIT  = 1'b1,
  localparam int unsigned WORD_W   = SPEED_W + SPEED_LSB,
  localparam int unsigned CNT_W    = $clog2(((2 ** SPEED_W) - 1) * MHZ_MULT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              tick
);

  logic [SPEED_W-1:0] speed;
  rate_unit_e         unit;
  logic               restart;
  logic [CNT_W-1:0]   period;

  mst_cfg_reg #(
    .SPEED_W  (SPEED_W),
    .RST_SPEED(RST_SPEED),
    .RST_UNIT (RST_UNIT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .wdata_i  (cfg_wdata),
    .rdata_o  (cfg_rdata),
    .speed_o  (speed),
    .unit_o   (unit),
    .restart_o(restart)
  );

  mst_period_calc #(
    .SPEED_W (SPEED_W),
    .MHZ_MULT(MHZ_MULT),
    .KHZ_MIN (KHZ_MIN),
    .MHZ_MIN (MHZ_MIN),
    .CNT_W   (CNT_W)
  ) u_calc (
    .clk     (clk),
    .rst_n   (rst_n),
    .speed_i (speed),
    .unit_i  (unit),
    .period_o(period)
  );

  mst_cycle_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .period_i (period),
    .tick_o   (tick)
  );

  // R7: the cycle after a changing write never carries a tick.
  p_no_tick_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R1: the reserved bit always reads zero.
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1] == 1'b0);

endmodule

// File: tb/ms_tick_gen_tb.sv
module ms_tick_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] cfg_rdata;
  logic        tick;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R5";
  bit    done     = 1'b0;

  // Behavioural reference state
  int m_speed = 48;
  int m_unit  = 1;
  int m_phase = 0;
  bit m_tick  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_tick_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .tick     (tick)
  );

  function automatic int period_of(int speed, int unit);
    int s;
    if (unit == 1) begin
      s = (speed < 1) ? 1 : speed;
      return s * 1000;
    end
    s = (speed < 4) ? 4 : speed;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_speed = 48; m_unit = 1; m_phase = 0; m_tick = 1'b0;
    end else if (cfg_we && ((int'(cfg_wdata[11:2]) != m_speed) || (int'(cfg_wdata[0]) != m_unit))) begin
      m_speed = int'(cfg_wdata[11:2]); m_unit = int'(cfg_wdata[0]);
      m_phase = 0; m_tick = 1'b0;
    end else if (m_phase == period_of(m_speed, m_unit) - 1) begin
      m_phase = 0; m_tick = 1'b1;
    end else begin
      m_phase++; m_tick = 1'b0;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (tick !== m_tick) begin
        n_fail++;
        $display("FAIL %s: tick actual %0b expected %0b at %0t", cur_req, tick, m_tick, $time);
      end
    end
  end

  task automatic check_rdata(string req, logic [11:0] exp);
    n_checks++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: cfg_rdata actual 0x%03h expected 0x%03h", req, cfg_rdata, exp);
    end
  endtask

  task automatic write_cfg(logic [11:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_count(string req, int cycles, int exp_ticks);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    n_checks++;
    if (seen != exp_ticks) begin
      n_fail++;
      $display("FAIL %s: tick count actual %0d expected %0d", req, seen, exp_ticks);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_rdata("R2", 12'h0C1);
    rst_n = 1'b1;
    // R2 / R5: default 48 MHz gives one tick after 48000 cycles
    cur_req = "R2";
    run_count("R2", 48005, 1);

    // R3: kHz mode, speed 7 -> 7 cycles
    cur_req = "R3";
    write_cfg(12'(7 << 2));
    check_rdata("R1", 12'h01C);
    run_count("R3", 70, 10);
    write_cfg(12'(13 << 2));
    run_count("R3", 130, 10);

    // R6: clamp floors
    cur_req = "R6";
    write_cfg(12'h000);
    check_rdata("R6", 12'h000);
    run_count("R6", 40, 10);
    write_cfg(12'(3 << 2));
    run_count("R6", 40, 10);
    write_cfg(12'h001);
    check_rdata("R6", 12'h001);
    run_count("R6", 3000, 3);

    // R4: MHz mode, speed 2 -> 2000 cycles
    cur_req = "R4";
    write_cfg(12'((2 << 2) | 1));
    run_count("R4", 4000, 2);

    // R8: same fields rewritten mid-period, bit 1 set
    cur_req = "R8";
    write_cfg(12'(10 << 2));
    repeat (6) @(negedge clk);
    write_cfg(12'((10 << 2) | 2));
    check_rdata("R1", 12'h028);
    run_count("R8", 100, 10);

    // R7: speed change mid-period, then unit-only change
    cur_req = "R7";
    repeat (3) @(negedge clk);
    write_cfg(12'(12 << 2));
    run_count("R7", 120, 10);
    repeat (5) @(negedge clk);
    write_cfg(12'((12 << 2) | 1));
    run_count("R7", 12000, 1);
    write_cfg(12'(5 << 2));
    run_count("R5", 50, 10);

    finish_run();
  end

endmodule